// File: doc/BRIEF.md
# Reloading Down-Counter Timer with Bus Registers

The block is a 32-bit down-counter behind a simple APB register slave. Software loads a start value, selects how the counter advances, and enables an interrupt. Each qualified tick takes one off the count. When the count steps from one to zero, an interrupt flag is latched. On the next tick the counter takes the reload value and the cycle repeats, so the period is the reload value plus one ticks.

A single external pin can steer the count in one of two ways. It can act as a level gate, so the count halts while the pin is low. It can also act as the tick source, so each rising edge of the pin is one tick. The pin passes through a two-flop synchroniser, and its rising edge is found in the bus clock domain. A fixed table of twelve identification bytes sits at the top of the 4 KB window.

The bus never stalls and never signals an error: PREADY is tied high and PSLVERR tied low. There is no streaming data path, so no valid/ready handshake applies. Reads return data combinationally during the access. A write takes effect on the clock edge that completes its access phase.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset the control, count, reload and status registers read 0, the interrupt output is low and the counter does not advance.
- R2: Word offsets are fixed. 0x000 is control, which keeps only data bits 3:0: bit0 run, bit1 gate-by-pin, bit2 tick-on-pin-edge, bit3 interrupt enable. 0x004 is the current count, 0x008 is the reload value and 0x00C is status. Each reads back what was stored.
- R3: While run is set, each tick lowers a nonzero count by one. Without run, the count holds. Without the pin modes, every bus clock is a tick.
- R4: A tick that takes the count from 1 to 0 sets status bit0, but only with the interrupt enable set. The interrupt output equals status bit0.
- R5: A tick that finds the count at 0 loads the reload value, so the count dwells at 0 for one tick and the period is reload+1 ticks.
- R6: With reload 0, the count stays at 0 on every tick and no interrupt is raised.
- R7: Writing the reload register loads both the reload value and the count. Writing the count register changes only the count. A bus write overrides a tick in the same cycle.
- R8: Writing 1 to status bit0 clears it and writing 0 leaves it. A new interrupt in the same cycle as a clear wins.
- R9: In gate mode, the count does not change while the synchronised pin is low.
- R10: In pin-edge mode, each rising edge of the pin gives exactly one tick, no more than three bus clocks after the edge. A pin held high gives no further ticks.
- R11: Offsets 0xFD0 to 0xFFC read the bytes 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in ascending word order. Writes there are ignored.
- R12: Unmapped or unaligned offsets read 0 and ignore writes. PREADY is always 1 and PSLVERR always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | Asynchronous external pin (gate or tick source) |
| irq | output | 1 | Level interrupt, equal to status bit0 |

## Verification
The dwell at zero and the reload after it are hard to observe on a free-running counter, because a read sees a value that shifts every clock. The stimulus therefore puts the timer in pin-edge mode and makes one pin pulse per step. This makes every count value stable and readable between pulses: the 1-to-0 step, the zero dwell and the reload. The reload-of-zero case and the clash between a status clear and a pending flag use the same stepping. One plain-clock run measures the exact clock count from enable to interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W = 10;

  localparam logic [WORD_W-1:0] W_CTRL   = 10'h000;
  localparam logic [WORD_W-1:0] W_COUNT  = 10'h001;
  localparam logic [WORD_W-1:0] W_RELOAD = 10'h002;
  localparam logic [WORD_W-1:0] W_STATUS = 10'h003;
  localparam logic [WORD_W-1:0] W_ID_LO  = 10'h3F4;
  localparam logic [WORD_W-1:0] W_ID_HI  = 10'h3FF;

  typedef struct packed {
    logic irq_en;
    logic pin_clk;
    logic pin_gate;
    logic run;
  } tmr_ctrl_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h22;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_level,
  output logic pin_rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_async};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign pin_level = chain_q[STAGES-1];
  assign pin_rise  = pin_level & ~prev_q;

  // R10: one edge yields one tick pulse
  a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             irq_en,
  input  logic             ld_count,
  input  logic             ld_reload,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic ld_any;
  assign ld_any = ld_count | ld_reload;
  assign fire   = tick & ~ld_any & irq_en & (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else if (ld_reload) begin
      reload <= wdata;
      count  <= wdata;
    end else if (ld_count) begin
      count <= wdata;
    end else if (tick) begin
      if (count == '0) count <= reload;
      else             count <= count - ONE;
    end
  end

  // R5: a tick at zero brings in the reload value
  a_r5_dwell_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_any && count == '0) |=> (count == $past(reload)));
  // R3: no tick and no write, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_any) |=> $stable(count));
  // R6: zero reload keeps the count at zero
  a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && reload == '0 && !ld_any) |=> (count == '0));
  // R4: the interrupt step lands on zero
  a_r4_fire_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (count == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [3:0]        wr_low,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] reload,
  input  logic              fire,
  output tmr_ctrl_t         ctrl,
  output logic              ld_count,
  output logic              ld_reload,
  output logic              flag,
  output logic [DATA_W-1:0] prdata
);
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              wr_en;
  logic              wr_ctrl, wr_stat;
  logic              in_id;
  logic [3:0]        id_idx;
  logic [DATA_W-1:0] rd_mux;

  assign aligned = (paddr[1:0] == 2'b00);
  assign word    = paddr[ADDR_W-1:2];
  assign wr_en   = psel & penable & pwrite & aligned;

  assign wr_ctrl   = wr_en & (word == W_CTRL);
  assign ld_count  = wr_en & (word == W_COUNT);
  assign ld_reload = wr_en & (word == W_RELOAD);
  assign wr_stat   = wr_en & (word == W_STATUS);

  assign in_id  = (word >= W_ID_LO) && (word <= W_ID_HI);
  assign id_idx = 4'(word - W_ID_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= tmr_ctrl_t'(wr_low);
      if (fire)                   flag <= 1'b1;
      else if (wr_stat && wr_low[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if      (word == W_CTRL)   rd_mux = DATA_W'(ctrl);
      else if (word == W_COUNT)  rd_mux = count;
      else if (word == W_RELOAD) rd_mux = reload;
      else if (word == W_STATUS) rd_mux = DATA_W'(flag);
      else if (in_id)            rd_mux = DATA_W'(id_byte(id_idx));
    end
  end

  assign prdata = (psel && !pwrite) ? rd_mux : '0;

  // R8: a one clears the flag unless a new event arrives
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_low[0] && !fire) |=> !flag);
  // R4: an event always latches
  a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);
  // R8: writing zero leaves the flag alone
  a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wr_low[0] && flag) |=> flag);
endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq
);
  tmr_ctrl_t         ctrl;
  logic              pin_level, pin_rise;
  logic              tick, src_ok, gate_ok;
  logic              ld_count, ld_reload, fire, flag;
  logic [DATA_W-1:0] count, reload;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_in),
    .pin_level(pin_level), .pin_rise(pin_rise)
  );

  always_comb begin
    src_ok  = ctrl.pin_clk  ? pin_rise  : 1'b1;
    gate_ok = ctrl.pin_gate ? pin_level : 1'b1;
    tick    = ctrl.run & src_ok & gate_ok;
  end

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .irq_en(ctrl.irq_en),
    .ld_count(ld_count), .ld_reload(ld_reload), .wdata(pwdata),
    .count(count), .reload(reload), .fire(fire)
  );

  tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .wr_low(pwdata[3:0]),
    .count(count), .reload(reload), .fire(fire), .ctrl(ctrl),
    .ld_count(ld_count), .ld_reload(ld_reload), .flag(flag),
    .prdata(prdata)
  );

  assign irq     = flag;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // R4: an interrupt rises only with the enable set
  a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl.irq_en));
  // R9: gated count holds while the pin is low
  a_r9_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pin_gate && !pin_level && !ld_count && !ld_reload) |=> $stable(count));
endmodule

// File: tb/apb_reload_timer_bench.sv
module apb_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        ext_in = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  apb_reload_timer u_apb_reload_timer (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp,
                        input string tag);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pin_pulse();
    @(posedge clk); #1; ext_in = 1'b1;
    repeat (4) @(posedge clk);
    #1; ext_in = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  // monitor: pops expected read data at each access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "monitor underflow", prdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(prdata === e, t, prdata, e);
        chk(pready === 1'b1 && pslverr === 1'b0, "R12 handshake",
            {30'h0, pslverr, pready}, 32'h1);
      end
    end
  end

  logic [31:0] id_tab [12] = '{32'h04, 32'h00, 32'h00, 32'h00,
                               32'h22, 32'hB8, 32'h1B, 32'h00,
                               32'h0D, 32'hF0, 32'h05, 32'hB1};

  bit finished = 1'b0;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (4) @(posedge clk);
    #1; rst_n = 1'b1;

    // R1 reset state
    #1 chk(irq === 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    bus_rd(12'h000, 32'h0, "R1 control");
    bus_rd(12'h004, 32'h0, "R1 count");
    bus_rd(12'h008, 32'h0, "R1 reload");
    bus_rd(12'h00C, 32'h0, "R1 status");

    // R11 identification table, write ignored
    for (int i = 0; i < 12; i++)
      bus_rd(12'hFD0 + 12'(i * 4), id_tab[i], "R11 id byte");
    bus_wr(12'hFE0, 32'hFFFF_FFFF);
    bus_rd(12'hFE0, 32'h22, "R11 id write ignored");

    // R12 unmapped and unaligned
    bus_wr(12'h010, 32'h0000_00FF);
    bus_rd(12'h010, 32'h0, "R12 unmapped read");
    bus_wr(12'h001, 32'h0000_000F);
    bus_rd(12'h000, 32'h0, "R12 unaligned write ignored");
    bus_rd(12'h005, 32'h0, "R12 unaligned read");

    // R2 control keeps low four bits
    bus_wr(12'h000, 32'h0000_00F0);
    bus_rd(12'h000, 32'h0, "R2 high bits dropped");
    bus_wr(12'h000, 32'h0000_00FA);
    bus_rd(12'h000, 32'hA, "R2 control low bits");
    bus_wr(12'h000, 32'h0);

    // R7 reload write loads count; count write keeps reload
    bus_wr(12'h008, 32'd5);
    bus_rd(12'h008, 32'd5, "R7 reload value");
    bus_rd(12'h004, 32'd5, "R7 reload loads count");
    bus_wr(12'h004, 32'd7);
    bus_rd(12'h004, 32'd7, "R7 count write");
    bus_rd(12'h008, 32'd5, "R7 reload kept");

    // R10/R4/R5 pin-edge stepping: run|pin_clk|irq_en = 0xD
    bus_wr(12'h004, 32'd2);
    bus_wr(12'h000, 32'hD);
    bus_rd(12'h004, 32'd2, "R10 no tick without edge");
    pin_pulse();
    bus_rd(12'h004, 32'd1, "R10 one tick per edge");
    pin_pulse();
    bus_rd(12'h004, 32'd0, "R4 step to zero");
    chk(irq === 1'b1, "R4 irq on 1-to-0", {31'h0, irq}, 32'h1);
    bus_rd(12'h00C, 32'h1, "R4 status set");
    pin_pulse();
    bus_rd(12'h004, 32'd5, "R5 reload after dwell");
    pin_pulse();
    bus_rd(12'h004, 32'd4, "R10 count after reload");

    // R8 write-one-to-clear
    bus_wr(12'h00C, 32'h0);
    bus_rd(12'h00C, 32'h1, "R8 zero write keeps");
    bus_wr(12'h00C, 32'h1);
    bus_rd(12'h00C, 32'h0, "R8 one write clears");
    chk(irq === 1'b0, "R8 irq cleared", {31'h0, irq}, 32'h0);

    // R4 no interrupt without enable: run|pin_clk = 0x5
    bus_wr(12'h000, 32'h5);
    bus_wr(12'h004, 32'd1);
    pin_pulse();
    bus_rd(12'h004, 32'd0, "R3 step without enable");
    bus_rd(12'h00C, 32'h0, "R4 no status without enable");
    chk(irq === 1'b0, "R4 irq stays low", {31'h0, irq}, 32'h0);

    // R6 zero reload
    bus_wr(12'h008, 32'd0);
    bus_wr(12'h000, 32'hD);
    repeat (3) pin_pulse();
    bus_rd(12'h004, 32'd0, "R6 stays at zero");
    bus_rd(12'h00C, 32'h0, "R6 no interrupt");

    // R3 halted count, including pin edges without run (0x4)
    bus_wr(12'h000, 32'h0);
    bus_wr(12'h004, 32'd4);
    repeat (10) @(posedge clk);
    bus_rd(12'h004, 32'd4, "R3 holds without run");
    bus_wr(12'h000, 32'h4);
    pin_pulse();
    bus_rd(12'h004, 32'd4, "R3 edge ignored without run");

    // R9 gate mode: run|pin_gate|irq_en = 0xB
    bus_wr(12'h000, 32'hB);
    bus_wr(12'h004, 32'd10);
    repeat (20) @(posedge clk);
    bus_rd(12'h004, 32'd10, "R9 gated low holds");
    @(posedge clk); #1; ext_in = 1'b1;
    k = 0;
    while (!irq && k < 60) begin @(posedge clk); #1; k++; end
    chk(irq === 1'b1, "R9 counts once pin high", {31'h0, irq}, 32'h1);
    ext_in = 1'b0;
    bus_wr(12'h000, 32'h0);
    bus_wr(12'h00C, 32'h1);

    // R3/R4 plain clock: interrupt exactly reload ticks after enable
    bus_wr(12'h008, 32'd6);
    bus_wr(12'h000, 32'h9);
    k = 0;
    while (!irq && k < 60) begin @(posedge clk); #1; k++; end
    chk(k == 6, "R3 clocks to interrupt", 32'(k), 32'd6);
    bus_wr(12'h000, 32'h0);
    bus_wr(12'h00C, 32'h1);
    chk(irq === 1'b0, "R8 final clear", {31'h0, irq}, 32'h0);

    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule